// File: doc/BRIEF.md
# Battery-Backed SRAM Chip-Enable Gate

This block sits between a host and an external 16-bit static RAM that is kept alive by a battery. It turns one host chip enable and two active-low byte-lane enables into two active-low chip enables, one per byte lane of the RAM. Lane selection is purely combinational, so the RAM sees the host's lane choice in the same cycle. The gating is added on top of that decode.

A power-fail flag write-protects the RAM: while the flag is high, both RAM enables are held inactive, and a supply-select output moves the RAM onto the battery. When the flag clears, the supply returns to main power, but access stays locked out until a programmable number of millisecond ticks has been counted. This gives the rest of the system time to settle before the RAM can be written again.

A three-state machine holds the gate's condition. ST_LOCKOUT counts ticks and is entered from reset and through the PF_EXIT transition from ST_FAIL. ST_ACTIVE allows access and is reached from ST_LOCKOUT through LOCK_DONE. ST_FAIL is entered from any state through PF_ENTER whenever power_fail is sampled high.

Top module: `sram_ce_gate`

## Requirements
- R1: With access_allowed=1, power_fail=0, ce_in_n=0, bhe_n=0 and ble_n=0, both ceol_n and ceoh_n are 0 in the same cycle (word access).
- R2: With access_allowed=1, power_fail=0, ce_in_n=0, bhe_n=0 and ble_n=1, ceoh_n is 0 and ceol_n is 1 in the same cycle (upper lane, data bits 15..8).
- R3: With access_allowed=1, power_fail=0, ce_in_n=0, bhe_n=1 and ble_n=0, ceol_n is 0 and ceoh_n is 1 in the same cycle (lower lane, data bits 7..0).
- R4: With ce_in_n=1, or with ce_in_n=0 and both bhe_n and ble_n at 1, both ceol_n and ceoh_n are 1.
- R5: While power_fail is 1, ceol_n and ceoh_n are both 1 in that same cycle, whatever ce_in_n, bhe_n and ble_n are.
- R6: supply_sel is 1 (battery) after each clock edge that samples power_fail=1 and 0 (main supply) after each edge that samples power_fail=0.
- R7: access_allowed is 0 during and after reset and after power_fail clears, and while it is 0 both RAM enables stay 1.
- R8: In ST_LOCKOUT, each cycle with ms_tick=1 counts once. access_allowed rises on the edge that samples the LOCK_TICKS-th such tick. Ticks during ST_FAIL or ST_ACTIVE have no effect.
- R9: access_allowed is 0 after any clock edge that samples power_fail=1.
- R10: If power_fail rises during a partial lockout count, the partial count is discarded, and after power_fail clears again a full LOCK_TICKS ticks are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_fail | input | 1 | Clean digital power-fail flag, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ce_in_n | input | 1 | Host chip enable, active low |
| bhe_n | input | 1 | Upper byte-lane enable, active low |
| ble_n | input | 1 | Lower byte-lane enable, active low |
| ceol_n | output | 1 | RAM lower-lane chip enable, active low |
| ceoh_n | output | 1 | RAM upper-lane chip enable, active low |
| supply_sel | output | 1 | 1 selects battery, 0 selects main supply |
| access_allowed | output | 1 | 1 when ST_ACTIVE grants RAM access |

## Verification
The decode is driven through all four byte-enable combinations with the host enable both low and high, and each combination is repeated in lockout, active and power-fail conditions. This separates a lane swap or a missing gate from a fault in the state machine. The lockout is checked one tick short of the limit and exactly at the limit, with ticks inserted during power fail to show they are ignored. A power-fail pulse in the middle of a lockout count shows whether the partial count is kept or discarded.

// File: rtl/sramgate_pkg.sv
package sramgate_pkg;

    typedef enum logic [1:0] {
        ST_LOCKOUT = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_FAIL    = 2'd2
    } gate_state_t;

    localparam int NUM_LANES = 2;
    localparam int LANE_LO   = 0;
    localparam int LANE_HI   = 1;

endpackage

// File: rtl/sramgate_tick_counter.sv
module sramgate_tick_counter #(
    parameter int LIMIT = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic tick,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // The limit-th tick while counting completes the interval
    assign done = count_en && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en && tick) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sramgate_lock_fsm.sv
module sramgate_lock_fsm
    import sramgate_pkg::*;
#(
    parameter int LOCK_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_fail,
    input  logic ms_tick,
    output logic access_en,
    output logic on_battery
);
    gate_state_t state_q, state_d;
    logic        cnt_clear;
    logic        cnt_run;
    logic        lock_done;

    sramgate_tick_counter #(
        .LIMIT (LOCK_TICKS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .count_en (cnt_run),
        .tick     (ms_tick),
        .done     (lock_done)
    );

    // Counting only happens in lockout; any other state holds it at zero
    assign cnt_run   = (state_q == ST_LOCKOUT) && !power_fail;
    assign cnt_clear = (state_q != ST_LOCKOUT) || power_fail;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKOUT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: PF_ENTER, PF_EXIT, LOCK_DONE
    always_comb begin
        state_d = state_q;
        if (power_fail) begin
            state_d = ST_FAIL;
        end else begin
            unique case (state_q)
                ST_FAIL:    state_d = ST_LOCKOUT;
                ST_LOCKOUT: state_d = lock_done ? ST_ACTIVE : ST_LOCKOUT;
                ST_ACTIVE:  state_d = ST_ACTIVE;
                default:    state_d = ST_LOCKOUT;
            endcase
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        access_en  = 1'b0;
        on_battery = 1'b0;
        unique case (state_q)
            ST_ACTIVE:  access_en  = 1'b1;
            ST_FAIL:    on_battery = 1'b1;
            ST_LOCKOUT: access_en  = 1'b0;
            default:    access_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/sramgate_lane_decode.sv
module sramgate_lane_decode
    import sramgate_pkg::*;
(
    input  logic                 grant,
    input  logic                 ce_in_n,
    input  logic [NUM_LANES-1:0] lane_en_n,
    output logic [NUM_LANES-1:0] lane_ce_n
);
    logic sel;

    assign sel = grant && !ce_in_n;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_ce_n[g] = !(sel && !lane_en_n[g]);
    end

endmodule

// File: rtl/sram_ce_gate.sv
module sram_ce_gate
    import sramgate_pkg::*;
#(
    parameter int LOCK_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_fail,
    input  logic ms_tick,
    input  logic ce_in_n,
    input  logic bhe_n,
    input  logic ble_n,
    output logic ceol_n,
    output logic ceoh_n,
    output logic supply_sel,
    output logic access_allowed
);
    logic                 access_en;
    logic                 on_battery;
    logic                 grant;
    logic [NUM_LANES-1:0] en_n;
    logic [NUM_LANES-1:0] ce_n;

    sramgate_lock_fsm #(
        .LOCK_TICKS (LOCK_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_fail (power_fail),
        .ms_tick    (ms_tick),
        .access_en  (access_en),
        .on_battery (on_battery)
    );

    // Power fail blocks the RAM at once, before the state register follows
    assign grant = access_en && !power_fail;

    assign en_n[LANE_LO] = ble_n;
    assign en_n[LANE_HI] = bhe_n;

    sramgate_lane_decode u_dec (
        .grant     (grant),
        .ce_in_n   (ce_in_n),
        .lane_en_n (en_n),
        .lane_ce_n (ce_n)
    );

    assign ceol_n         = ce_n[LANE_LO];
    assign ceoh_n         = ce_n[LANE_HI];
    assign supply_sel     = on_battery;
    assign access_allowed = access_en;

endmodule

// File: rtl/sram_ce_gate_chk.sv
module sram_ce_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic power_fail,
    input logic ms_tick,
    input logic ce_in_n,
    input logic bhe_n,
    input logic ble_n,
    input logic ceol_n,
    input logic ceoh_n,
    input logic supply_sel,
    input logic access_allowed
);
    // R1
    word_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_allowed && !power_fail && !ce_in_n && !bhe_n && !ble_n) |-> (!ceol_n && !ceoh_n));

    // R4
    host_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_in_n |-> (ceol_n && ceoh_n));

    // R5
    pf_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_fail |-> (ceol_n && ceoh_n));

    // R6
    battery_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_fail |=> supply_sel);

    // R6
    main_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power_fail |=> !supply_sel);

    // R7
    locked_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !access_allowed |-> (ceol_n && ceoh_n));

    // R8
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_allowed) |-> ($past(ms_tick) && !$past(power_fail)));

    // R9
    pf_drops_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_fail |=> !access_allowed);

endmodule

bind sram_ce_gate sram_ce_gate_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .power_fail     (power_fail),
    .ms_tick        (ms_tick),
    .ce_in_n        (ce_in_n),
    .bhe_n          (bhe_n),
    .ble_n          (ble_n),
    .ceol_n         (ceol_n),
    .ceoh_n         (ceoh_n),
    .supply_sel     (supply_sel),
    .access_allowed (access_allowed)
);

// File: tb/sram_ce_gate_bench.sv
module sram_ce_gate_bench;

    localparam int LOCK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic power_fail = 1'b0;
    logic ms_tick = 1'b0;
    logic ce_in_n = 1'b1;
    logic bhe_n = 1'b1;
    logic ble_n = 1'b1;
    logic ceol_n, ceoh_n, supply_sel, access_allowed;

    always #10 clk = ~clk;

    sram_ce_gate #(.LOCK_TICKS(LOCK)) u_sram_ce_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .power_fail     (power_fail),
        .ms_tick        (ms_tick),
        .ce_in_n        (ce_in_n),
        .bhe_n          (bhe_n),
        .ble_n          (ble_n),
        .ceol_n         (ceol_n),
        .ceoh_n         (ceoh_n),
        .supply_sel     (supply_sel),
        .access_allowed (access_allowed)
    );

    typedef struct {
        logic  l;
        logic  h;
        logic  sup;
        logic  allow;
        string tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // Reference model state, from the requirements
    logic m_allow = 0, m_sup = 0, m_fail = 0;
    int   m_cnt = 0;

    // Monitor: pop expected item and compare with ports
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            e = q.pop_front();
            checks++;
            if (ceol_n !== e.l || ceoh_n !== e.h || supply_sel !== e.sup || access_allowed !== e.allow) begin
                fails++;
                $display("FAIL %s: got l=%b h=%b sup=%b allow=%b, expected l=%b h=%b sup=%b allow=%b",
                         e.tag, ceol_n, ceoh_n, supply_sel, access_allowed, e.l, e.h, e.sup, e.allow);
            end
        end
    end

    // Driver: apply one cycle of stimulus, push expectation, advance model
    task automatic step(input logic pf, input logic tk, input logic ce,
                        input logic bh, input logic bl, input string tag);
        exp_t e;
        logic en;
        @(negedge clk);
        power_fail = pf; ms_tick = tk; ce_in_n = ce; bhe_n = bh; ble_n = bl;
        en      = m_allow && !pf && !ce;
        e.l     = !(en && !bl);
        e.h     = !(en && !bh);
        e.sup   = m_sup;
        e.allow = m_allow;
        e.tag   = tag;
        q.push_back(e);
        #5;
        ->chk_ev;
        if (pf) begin
            m_fail = 1; m_sup = 1; m_allow = 0; m_cnt = 0;
        end else if (m_fail) begin
            m_fail = 0; m_sup = 0; m_cnt = 0;
        end else if (!m_allow && tk) begin
            if (m_cnt == LOCK - 1) begin
                m_allow = 1; m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R7: reset state checked while reset is held
        repeat (2) @(negedge clk);
        ce_in_n = 0; bhe_n = 0; ble_n = 0;
        #5;
        checks++;
        if (ceol_n !== 1 || ceoh_n !== 1 || supply_sel !== 0 || access_allowed !== 0) begin
            fails++;
            $display("FAIL R7 reset: got l=%b h=%b sup=%b allow=%b, expected 1 1 0 0",
                     ceol_n, ceoh_n, supply_sel, access_allowed);
        end
        @(negedge clk);
        rst_n = 1;

        // R7/R8: lockout after reset, one tick short then the last one
        for (int i = 0; i < LOCK - 1; i++) begin
            step(0, 1, 0, 0, 0, "R8 lockout tick");
            step(0, 0, 0, 0, 0, "R7 still locked");
        end
        step(0, 1, 0, 0, 0, "R8 final tick");
        step(0, 0, 0, 0, 0, "R1 word after unlock");

        // R1..R4: decode patterns
        step(0, 0, 0, 0, 1, "R2 upper lane");
        step(0, 0, 0, 1, 0, "R3 lower lane");
        step(0, 0, 0, 1, 1, "R4 no lane");
        step(0, 0, 1, 0, 0, "R4 host disabled");
        step(0, 1, 0, 0, 0, "R8 tick in active ignored");

        // R5/R6/R9: power fail with every pattern
        step(1, 0, 0, 0, 0, "R5 pf word");
        step(1, 1, 0, 0, 1, "R6 battery, R8 tick in fail");
        step(1, 1, 0, 1, 0, "R9 access dropped");
        step(1, 0, 1, 1, 1, "R5 pf idle");
        step(0, 0, 0, 0, 0, "R6 main restored");
        step(0, 0, 0, 0, 0, "R7 locked after pf");

        // R10: partial count then another power fail
        for (int i = 0; i < LOCK - 2; i++) step(0, 1, 0, 0, 0, "R10 partial tick");
        step(1, 0, 0, 0, 0, "R10 pf mid lockout");
        step(0, 0, 0, 0, 0, "R10 pf cleared");
        for (int i = 0; i < LOCK - 1; i++) step(0, 1, 0, 0, 0, "R10 recount");
        step(0, 0, 0, 0, 0, "R10 still locked");
        step(0, 1, 0, 1, 0, "R10 final tick");
        step(0, 0, 0, 1, 0, "R3 lower after relock");
        step(0, 0, 0, 0, 1, "R2 upper after relock");
        step(0, 0, 1, 1, 1, "R4 end idle");

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule